// File: doc/BRIEF.md
# Sub-page write guard

This block decides whether a guest write may proceed when write rights are kept per 128-byte slice of a 4KB page. Each request carries the guest physical and linear addresses, the write flag, and two bits from the page-level leaf translation entry: writable and sub-page-enable. The block also takes a global enable input and a pointer to the root of the permission table. If the write is subject to slice checking, the block reads a four-level table through a single-outstanding memory read port. The last read returns a 64-bit bitmap that holds one write bit per slice.

Every request ends with a one-cycle done pulse. The pulse carries one of four outcomes: allow, violation, miss or misconfiguration. A miss or a misconfiguration also carries an exit code and a qualification word that the fault handler uses. Only one request is in flight at a time. While a request is in flight, the block holds its request-ready output low.

Top module: `subpg_wr_guard`

## Requirements
- R1: A request that is not a write finishes as allow (outcome code 0) and makes no table read.
- R2: A write with the global enable low or the leaf sub-page-enable bit clear makes no table read. It finishes as allow if the leaf is writable, and as violation (code 1) if it is not.
- R3: A write with both enables set and the leaf writable finishes as allow and makes no table read.
- R4: A walk makes up to four reads, from level 4 down to level 1. The first table base is the root pointer masked to bits PA_W-1:12. Each following base is bits PA_W-1:12 of the entry just read. The read address is base + 8*index, with the index taken from guest physical address bits 47:39, 38:30, 29:21 and 20:12 for levels 4 to 1.
- R5: In a level 4, 3 or 2 entry, a nonzero bit in 11:1 or in 63:PA_W ends the walk as misconfiguration (code 3). No further read follows.
- R6: In a level 4, 3 or 2 entry with clean reserved bits, a clear bit 0 ends the walk as miss (code 2). If the reserved bits are also nonzero, misconfiguration wins.
- R7: A level 1 entry with any odd bit set ends the walk as misconfiguration.
- R8: In a clean level 1 entry, bit 2i decides the write, where i is guest physical address bits 11:7. A set bit gives allow and a clear bit gives violation.
- R9: Miss and misconfiguration report exit code 66. Their qualification word has bit 11 set for a miss and clear for a misconfiguration, and every other bit is zero. Allow and violation report code 0 and qualification 0. The request's guest physical and linear addresses are echoed with every result.
- R10: The done output is high for exactly one cycle per request. Request-ready stays low from acceptance until after that pulse.
- R11: A memory read request is 8-byte aligned, and it holds its address stable until it is accepted.
- R12: After a synchronous reset, request-ready is high and done and memory request are low, even if a walk was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_gpa | input | 64 | Guest physical address |
| req_gla | input | 64 | Guest linear address |
| req_is_write | input | 1 | Access is a write |
| req_leaf_wr | input | 1 | Leaf translation entry grants page write |
| req_leaf_sp_en | input | 1 | Leaf translation entry enables slice checking |
| prot_enable | input | 1 | Global slice-checking enable |
| root_ptr | input | 64 | Permission table root pointer |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address, 8-byte aligned |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done_valid | output | 1 | One-cycle result pulse |
| done_outcome | output | 2 | 0 allow, 1 violation, 2 miss, 3 misconfiguration |
| done_reason | output | 16 | Exit code: 66 for miss or misconfiguration, otherwise 0 |
| done_qual | output | 64 | Exit qualification word |
| done_gpa | output | 64 | Echoed guest physical address |
| done_gla | output | 64 | Echoed guest linear address |

## Verification
The hardest cases to reach are the deep endings: a misconfiguration or miss found at level 2 or level 1 after several clean reads, and an entry whose present bit is clear while its reserved bits are nonzero. The bench's memory responder serves a vector-specific list of four entries and checks each read address against a base chain it computes on its own. A vector can therefore place a fault at any chosen depth. Some vectors also hold off read acceptance for two cycles, and one walk is cut short by a reset while its read is outstanding.

// File: rtl/subpg_guard_pkg.sv
package subpg_guard_pkg;

    typedef enum logic [1:0] {
        OUT_ALLOW  = 2'd0,
        OUT_VIOL   = 2'd1,
        OUT_MISS   = 2'd2,
        OUT_MISCFG = 2'd3
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [63:0] gpa;
        logic [63:0] gla;
        logic        is_write;
        logic        leaf_wr;
        logic        leaf_sp_en;
        logic        prot_en;
    } walk_req_t;

    typedef struct packed {
        logic     descend;
        outcome_e result;
    } entry_verdict_t;

    localparam int TBL_EXIT_CODE = 66;
    localparam int QUAL_MISS_BIT = 11;

    // Bits of an entry or pointer that form a 4KB-aligned table base.
    function automatic logic [63:0] table_addr_mask(input int pa_w);
        return ((64'd1 << pa_w) - 64'd1) & ~64'h0000_0000_0000_0FFF;
    endfunction

endpackage

// File: rtl/subpg_index_sel.sv
module subpg_index_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int TOP   = 12 + IDX_W * LEVELS - 1
) (
    input  logic [TOP:7]       gpa_bits,
    input  logic [LVL_W-1:0]   level,
    output logic [IDX_W-1:0]   idx,
    output logic [4:0]         sub_idx
);
    logic [IDX_W-1:0] fields [LEVELS];

    // fields[0] indexes the leaf table, fields[LEVELS-1] the root table
    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign fields[g] = gpa_bits[12 + IDX_W * g +: IDX_W];
    end

    assign idx     = fields[level];
    assign sub_idx = gpa_bits[11:7];
endmodule

// File: rtl/subpg_entry_check.sv
module subpg_entry_check
    import subpg_guard_pkg::*;
#(
    parameter int PA_W = 46
) (
    input  logic [63:0]    entry,
    input  logic           is_leaf,
    input  logic [4:0]     sub_idx,
    output entry_verdict_t verdict,
    output logic [63:0]    next_base
);
    localparam logic [63:0] ADDR_MASK = table_addr_mask(PA_W);
    localparam logic [63:0] RESV_MASK = ~ADDR_MASK & ~64'h1;
    localparam logic [63:0] LEAF_RESV = 64'hAAAA_AAAA_AAAA_AAAA;

    always_comb begin
        next_base       = entry & ADDR_MASK;
        verdict.descend = 1'b0;
        verdict.result  = OUT_ALLOW;
        if (is_leaf) begin
            if ((entry & LEAF_RESV) != 64'd0) begin
                verdict.result = OUT_MISCFG;
            end else if (entry[{sub_idx, 1'b0}]) begin
                verdict.result = OUT_ALLOW;
            end else begin
                verdict.result = OUT_VIOL;
            end
        end else begin
            if ((entry & RESV_MASK) != 64'd0) begin
                verdict.result = OUT_MISCFG;
            end else if (!entry[0]) begin
                verdict.result = OUT_MISS;
            end else begin
                verdict.descend = 1'b1;
            end
        end
    end
endmodule

// File: rtl/subpg_exit_fmt.sv
module subpg_exit_fmt
    import subpg_guard_pkg::*;
#(
    parameter int REASON_W = 16
) (
    input  outcome_e            outcome,
    output logic [REASON_W-1:0] reason,
    output logic [63:0]         qual
);
    always_comb begin
        reason = '0;
        qual   = '0;
        if (outcome == OUT_MISS || outcome == OUT_MISCFG) begin
            reason = REASON_W'(TBL_EXIT_CODE);
        end
        if (outcome == OUT_MISS) begin
            qual[QUAL_MISS_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/subpg_wr_guard.sv
module subpg_wr_guard
    import subpg_guard_pkg::*;
#(
    parameter int PA_W     = 46,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int REASON_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [63:0]         req_gpa,
    input  logic [63:0]         req_gla,
    input  logic                req_is_write,
    input  logic                req_leaf_wr,
    input  logic                req_leaf_sp_en,
    input  logic                prot_enable,
    input  logic [63:0]         root_ptr,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [63:0]         mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_data,
    output logic                done_valid,
    output logic [1:0]          done_outcome,
    output logic [REASON_W-1:0] done_reason,
    output logic [63:0]         done_qual,
    output logic [63:0]         done_gpa,
    output logic [63:0]         done_gla
);
    localparam int LVL_W   = $clog2(LEVELS);
    localparam int GPA_TOP = 12 + IDX_W * LEVELS - 1;
    localparam logic [63:0] ROOT_MASK = table_addr_mask(PA_W);

    walk_st_e         state_q;
    walk_req_t        req_q;
    walk_req_t        req_in;
    logic [LVL_W-1:0] level_q;
    logic [63:0]      base_q;
    outcome_e         outcome_q;

    logic [IDX_W-1:0] idx;
    logic [4:0]       sub_idx;
    entry_verdict_t   verdict;
    logic [63:0]      next_base;
    logic [63:0]      root_base;
    logic             needs_walk;
    outcome_e         quick_outcome;

    assign req_in = '{gpa: req_gpa, gla: req_gla, is_write: req_is_write,
                      leaf_wr: req_leaf_wr, leaf_sp_en: req_leaf_sp_en,
                      prot_en: prot_enable};

    assign root_base = root_ptr & ROOT_MASK;

    // Decision for requests that never reach the table
    always_comb begin
        needs_walk    = 1'b0;
        quick_outcome = OUT_ALLOW;
        if (req_in.is_write) begin
            if (req_in.prot_en && req_in.leaf_sp_en) begin
                needs_walk = !req_in.leaf_wr;
            end else if (!req_in.leaf_wr) begin
                quick_outcome = OUT_VIOL;
            end
        end
    end

    subpg_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
        .gpa_bits (req_q.gpa[GPA_TOP:7]),
        .level    (level_q),
        .idx      (idx),
        .sub_idx  (sub_idx)
    );

    subpg_entry_check #(.PA_W(PA_W)) u_chk_ent (
        .entry     (mem_rsp_data),
        .is_leaf   (level_q == '0),
        .sub_idx   (sub_idx),
        .verdict   (verdict),
        .next_base (next_base)
    );

    subpg_exit_fmt #(.REASON_W(REASON_W)) u_fmt (
        .outcome (outcome_q),
        .reason  (done_reason),
        .qual    (done_qual)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            req_q     <= '0;
            level_q   <= '0;
            base_q    <= '0;
            outcome_q <= OUT_ALLOW;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        if (needs_walk) begin
                            level_q <= LVL_W'(LEVELS - 1);
                            base_q  <= root_base;
                            state_q <= ST_ISSUE;
                        end else begin
                            outcome_q <= quick_outcome;
                            state_q   <= ST_DONE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (verdict.descend) begin
                            base_q  <= next_base;
                            level_q <= level_q - 1'b1;
                            state_q <= ST_ISSUE;
                        end else begin
                            outcome_q <= verdict.result;
                            state_q   <= ST_DONE;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = base_q + {{(64 - IDX_W - 3){1'b0}}, idx, 3'b000};
    assign done_valid    = (state_q == ST_DONE);
    assign done_outcome  = outcome_q;
    assign done_gpa      = req_q.gpa;
    assign done_gla      = req_q.gla;
endmodule

// File: rtl/subpg_wr_guard_chk.sv
module subpg_wr_guard_chk #(
    parameter int REASON_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                req_ready,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [63:0]         mem_req_addr,
    input logic                done_valid,
    input logic [1:0]          done_outcome,
    input logic [REASON_W-1:0] done_reason,
    input logic [63:0]         done_qual
);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    a_r10_busy_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || done_valid) |-> !req_ready);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r11_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    a_r9_exit_code: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_outcome[1]) |->
            (done_reason == REASON_W'(66)
             && done_qual[11] == (done_outcome == 2'd2)
             && (done_qual & ~(64'd1 << 11)) == 64'd0));

    a_r9_no_exit: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !done_outcome[1]) |-> (done_reason == '0 && done_qual == 64'd0));

    a_r12_reset_idle: assert property (@(posedge clk)
        rst |=> (req_ready && !done_valid && !mem_req_valid));
endmodule

bind subpg_wr_guard subpg_wr_guard_chk #(.REASON_W(REASON_W)) u_assert (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_outcome  (done_outcome),
    .done_reason   (done_reason),
    .done_qual     (done_qual)
);

// File: tb/subpg_wr_guard_tb.sv
module subpg_wr_guard_tb;
    localparam int PA_W = 46;
    localparam logic [63:0] ROOT_RAW = 64'hFFF0_0012_3456_7ABC;
    localparam logic [63:0] BMASK    = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;
    localparam logic [63:0] GPA_OK   = 64'h0000_1234_5678_9100; // slice 2
    localparam logic [63:0] GPA_BAD  = 64'h0000_1234_5678_9180; // slice 3
    localparam logic [63:0] GPA_TOP  = 64'h0000_1234_5678_9F80; // slice 31
    localparam logic [63:0] P4 = 64'h0000_0000_0A00_0001;
    localparam logic [63:0] P3 = 64'h0000_0000_0B00_0001;
    localparam logic [63:0] P2 = 64'h0000_0000_0C00_0001;
    localparam logic [63:0] LF = 64'h4000_0000_0000_0015; // slices 0,1,2,31

    typedef struct packed {
        logic [3:0]  req;
        logic [63:0] gpa;
        logic        wr, leaf_w, leaf_sp, en, stall;
        logic [63:0] e4, e3, e2, e1;
        logic [1:0]  exp_out;
        logic [2:0]  exp_reads;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd1, GPA_OK,  1'b0,1'b0,1'b1,1'b1,1'b0, P4,P3,P2,LF, 2'd0, 3'd0}, // R1 read
        '{4'd2, GPA_OK,  1'b1,1'b0,1'b1,1'b0,1'b0, P4,P3,P2,LF, 2'd1, 3'd0}, // R2 global off
        '{4'd2, GPA_OK,  1'b1,1'b1,1'b0,1'b1,1'b0, P4,P3,P2,LF, 2'd0, 3'd0}, // R2 leaf bit off, writable
        '{4'd2, GPA_OK,  1'b1,1'b0,1'b0,1'b1,1'b0, P4,P3,P2,LF, 2'd1, 3'd0}, // R2 leaf bit off, read-only
        '{4'd3, GPA_OK,  1'b1,1'b1,1'b1,1'b1,1'b0, P4,P3,P2,LF, 2'd0, 3'd0}, // R3 writable skips walk
        '{4'd8, GPA_OK,  1'b1,1'b0,1'b1,1'b1,1'b0, P4,P3,P2,LF, 2'd0, 3'd4}, // R8 allow, R4 chain
        '{4'd8, GPA_BAD, 1'b1,1'b0,1'b1,1'b1,1'b1, P4,P3,P2,LF, 2'd1, 3'd4}, // R8 violation, stalled
        '{4'd8, GPA_TOP, 1'b1,1'b0,1'b1,1'b1,1'b0, P4,P3,P2,LF, 2'd0, 3'd4}, // R8 last slice
        '{4'd5, GPA_OK,  1'b1,1'b0,1'b1,1'b1,1'b0, 64'h0A00_0003,P3,P2,LF, 2'd3, 3'd1}, // R5 low reserved
        '{4'd5, GPA_OK,  1'b1,1'b0,1'b1,1'b1,1'b1, P4,64'h0000_4000_0B00_0001,P2,LF, 2'd3, 3'd2}, // R5 high reserved
        '{4'd6, GPA_OK,  1'b1,1'b0,1'b1,1'b1,1'b0, P4,64'h0B00_0000,P2,LF, 2'd2, 3'd2}, // R6 miss at L3
        '{4'd6, GPA_OK,  1'b1,1'b0,1'b1,1'b1,1'b0, P4,P3,64'h0C00_0002,LF, 2'd3, 3'd3}, // R6 priority
        '{4'd7, GPA_OK,  1'b1,1'b0,1'b1,1'b1,1'b0, P4,P3,P2,64'h17, 2'd3, 3'd4},        // R7 odd bit
        '{4'd6, GPA_OK,  1'b1,1'b0,1'b1,1'b1,1'b0, 64'd0,P3,P2,LF, 2'd2, 3'd1}          // R6 miss at root
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [63:0] req_gpa = '0, req_gla = '0;
    logic        req_is_write = 1'b0, req_leaf_wr = 1'b0, req_leaf_sp_en = 1'b0;
    logic        prot_enable = 1'b0;
    logic [63:0] root_ptr = ROOT_RAW;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [1:0]  done_outcome;
    logic [15:0] done_reason;
    logic [63:0] done_qual, done_gpa, done_gla;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    subpg_wr_guard #(.PA_W(PA_W)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input vec_t v, input int k);
        case (k)
            0: return v.e4;
            1: return v.e3;
            2: return v.e2;
            default: return v.e1;
        endcase
    endfunction

    // Address of the k-th read (k=0 is level 4), rebuilt from R4
    function automatic logic [63:0] exp_addr(input vec_t v, input int k);
        logic [63:0] base;
        logic [63:0] idx;
        base = ROOT_RAW & BMASK;
        for (int j = 0; j < k; j++) base = ent(v, j) & BMASK;
        idx = (v.gpa >> (12 + 9 * (3 - k))) & 64'h1FF;
        return base + (idx << 3);
    endfunction

    task automatic run_vec(input int n);
        vec_t v;
        int reads, waitc;
        bit pending, got, busy_bad;
        logic [1:0] out;
        logic [15:0] rsn;
        logic [63:0] q, g, l;
        string tag;
        v = VECS[n];
        tag = $sformatf("vector %0d R%0d", n, v.req);
        reads = 0; waitc = 0; pending = 0; got = 0; busy_bad = 0;
        out = '0; rsn = '0; q = '0; g = '0; l = '0;
        @(negedge clk);
        req_valid = 1'b1; req_gpa = v.gpa; req_gla = v.gpa ^ 64'h5A5A_0000_0000_00A5;
        req_is_write = v.wr; req_leaf_wr = v.leaf_w; req_leaf_sp_en = v.leaf_sp; prot_enable = v.en;
        for (int c = 0; c < 60 && !got; c++) begin
            @(negedge clk);
            req_valid = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
            if (req_ready) busy_bad = 1;
            if (done_valid) begin
                got = 1; out = done_outcome; rsn = done_reason; q = done_qual;
                g = done_gpa; l = done_gla;
            end else if (mem_req_valid) begin
                if (v.stall && waitc < 2) begin
                    waitc++;
                end else begin
                    // R4: address of each level read
                    chk(mem_req_addr == exp_addr(v, reads), {tag, " R4 addr"}, mem_req_addr, exp_addr(v, reads));
                    mem_req_ready = 1'b1; pending = 1; waitc = 0;
                end
            end else if (pending) begin
                mem_rsp_valid = 1'b1; mem_rsp_data = ent(v, reads); reads++; pending = 0;
            end
        end
        chk(got, {tag, " done"}, 64'(got), 64'd1);
        chk(out == v.exp_out, {tag, " outcome"}, 64'(out), 64'(v.exp_out));
        chk(reads == int'(v.exp_reads), {tag, " reads"}, 64'(reads), 64'(v.exp_reads));
        // R9 exit fields
        chk(rsn == ((v.exp_out >= 2) ? 16'd66 : 16'd0), {tag, " R9 reason"}, 64'(rsn), (v.exp_out >= 2) ? 64'd66 : 64'd0);
        chk(q == ((v.exp_out == 2) ? 64'h800 : 64'd0), {tag, " R9 qual"}, q, (v.exp_out == 2) ? 64'h800 : 64'd0);
        chk(g == v.gpa && l == (v.gpa ^ 64'h5A5A_0000_0000_00A5), {tag, " R9 echo"}, g, v.gpa);
        // R10 ready held low while busy, done lasts one cycle
        chk(!busy_bad, {tag, " R10 busy ready"}, 64'(busy_bad), 64'd0);
        @(negedge clk);
        chk(!done_valid && req_ready, {tag, " R10 pulse"}, 64'(done_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk(req_ready && !done_valid && !mem_req_valid, "R12 reset state",
            {61'd0, req_ready, done_valid, mem_req_valid}, 64'h4);
        for (int n = 0; n < NV; n++) run_vec(n);

        // R12: reset while a walk waits for its read data
        @(negedge clk);
        req_valid = 1'b1; req_gpa = GPA_OK; req_is_write = 1'b1;
        req_leaf_wr = 1'b0; req_leaf_sp_en = 1'b1; prot_enable = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req_valid, "R12 walk started", 64'(mem_req_valid), 64'd1);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !done_valid && !mem_req_valid, "R12 reset mid-walk",
            {61'd0, req_ready, done_valid, mem_req_valid}, 64'h4);
        repeat (3) @(negedge clk);
        chk(!done_valid && !mem_req_valid, "R12 stays idle", 64'(done_valid | mem_req_valid), 64'd0);

        // The block must accept a fresh walk after the reset (R8 allow)
        run_vec(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule